// File: doc/BRIEF.md
# DMA Channel Control Register Bank

A memory-mapped register bank for a multi-channel DMA controller, with 14 channels by default. It holds three per-channel masks: a high-priority mask, an enable mask and an error status. Bit C of each mask belongs to channel C. Software reaches the bank over a plain register bus with address, write enable, write data and read data. Each mask that software controls has two aliases. Writing ones to the set alias raises bits, and writing ones to the clear alias drops them. A zero in the write data leaves a bit as it is, so software never needs a read-modify-write sequence.

The controller side reports faults to the bank. A bus error arrives as a one-cycle pulse on that channel's bit of a vector. A descriptor fetch reports the channel and the descriptor's 3-bit cycle-control field, and the value 3'b000 marks the descriptor as invalid. Either fault latches the channel's error bit and clears that channel's enable bit. No other channel changes. The priority and enable masks drive an external arbiter directly. Reads are combinational from the address, and all writes and events take effect at the next rising clock edge.

Top module: `dma_chan_ctl_regs`

## Requirements
- R1: After reset, the priority, enable and error masks are all zero, and so are the mask outputs.
- R2: A write to offset 0x38 sets priority bit C for every 1 in data bit C, and leaves bits written 0 unchanged. A read of 0x38 returns the priority mask in bits [13:0], where 1 means high priority.
- R3: A write to offset 0x3C clears priority bit C for every 1 in data bit C, and leaves bits written 0 unchanged. Offset 0x3C reads as zero.
- R4: Offset 0x28 sets enable bits and offset 0x2C clears them, with the same write-one rules as R2 and R3. A read of 0x28 returns the enable mask, and 0x2C reads as zero.
- R5: Data bits [31:14] are ignored on writes and read back as zero.
- R6: A pulse on bit C of the bus-error input sets error bit C at the next clock edge.
- R7: A descriptor-fetch pulse whose channel index is C (below 14) and whose cycle-control field is 3'b000 sets error bit C. A nonzero field, or a channel index of 14 or more, sets no error bit.
- R8: A fault on channel C clears enable bit C. This wins over a same-cycle write that sets that enable bit. Other channels' enable bits and all priority bits are unaffected.
- R9: Writing 1 to bit C at offset 0x4C clears error bit C, and writing 0 has no effect. A read of 0x4C returns the error mask.
- R10: If a fault and a write-one-to-clear hit the same error bit in the same cycle, the bit stays set.
- R11: Writes to any offset other than 0x28, 0x2C, 0x38, 0x3C or 0x4C change no state and read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| addr_i | input | 8 | Register byte offset |
| wr_en_i | input | 1 | Write strobe for the current address |
| wr_data_i | input | 32 | Write data |
| rd_data_o | output | 32 | Read data for the current address (combinational) |
| bus_err_i | input | 14 | Per-channel bus-error pulses |
| desc_fetch_i | input | 1 | Descriptor-fetch result valid pulse |
| desc_chan_i | input | 4 | Channel index of the fetched descriptor |
| desc_cycctl_i | input | 3 | Cycle-control field of the fetched descriptor |
| prio_mask_o | output | 14 | High-priority mask to the arbiter |
| en_mask_o | output | 14 | Channel enable mask to the arbiter |

## Verification
Writing zeros through each alias checks the no-effect rule. A bank that wrote the data straight into the mask would wipe every bit instead. Writes carrying ones in bits [31:14], a full clear through 0x3C, and writes to an unused offset show that extra bits and stray addresses leave the masks alone. Faults are raised in the same cycle as an enable-set write on that channel and as an error clear on that bit. A design that gave the software write priority would leave a faulted channel enabled, or lose its error record. Invalid-descriptor detection is tried with a nonzero cycle-control field and with channel index 15, which must both be ignored. A decoder that looked only at the low index bits would corrupt another channel.

// File: rtl/dma_ctl_pkg.sv
`timescale 1ns/1ps
package dma_ctl_pkg;
  localparam int unsigned NUM_CH_DEF = 14;
  localparam int unsigned DATA_W_DEF = 32;
  localparam int unsigned ADDR_W_DEF = 8;
  localparam int unsigned CC_W       = 3;

  localparam int unsigned OFS_EN_SET  = 'h28;
  localparam int unsigned OFS_EN_CLR  = 'h2C;
  localparam int unsigned OFS_PRI_SET = 'h38;
  localparam int unsigned OFS_PRI_CLR = 'h3C;
  localparam int unsigned OFS_ERR     = 'h4C;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_EN_SET,
    SEL_EN_CLR,
    SEL_PRI_SET,
    SEL_PRI_CLR,
    SEL_ERR
  } reg_sel_e;
endpackage

// File: rtl/dma_reg_decode.sv
`timescale 1ns/1ps
module dma_reg_decode
  import dma_ctl_pkg::*;
#(
  parameter int unsigned ADDR_W = ADDR_W_DEF
) (
  input  logic [ADDR_W-1:0] addr_i,
  output reg_sel_e          sel_o
);
  always_comb begin
    sel_o = SEL_NONE;
    if      (addr_i == ADDR_W'(OFS_EN_SET))  sel_o = SEL_EN_SET;
    else if (addr_i == ADDR_W'(OFS_EN_CLR))  sel_o = SEL_EN_CLR;
    else if (addr_i == ADDR_W'(OFS_PRI_SET)) sel_o = SEL_PRI_SET;
    else if (addr_i == ADDR_W'(OFS_PRI_CLR)) sel_o = SEL_PRI_CLR;
    else if (addr_i == ADDR_W'(OFS_ERR))     sel_o = SEL_ERR;
  end
endmodule

// File: rtl/dma_err_event.sv
`timescale 1ns/1ps
module dma_err_event
  import dma_ctl_pkg::*;
#(
  parameter int unsigned NUM_CH   = NUM_CH_DEF,
  parameter int unsigned CH_IDX_W = $clog2(NUM_CH)
) (
  input  logic [NUM_CH-1:0]   bus_err_i,
  input  logic                desc_fetch_i,
  input  logic [CH_IDX_W-1:0] desc_chan_i,
  input  logic [CC_W-1:0]     desc_cycctl_i,
  output logic [NUM_CH-1:0]   ev_o
);
  logic desc_bad;
  assign desc_bad = desc_fetch_i && (desc_cycctl_i == '0);

  // index values at or above NUM_CH match no generated channel
  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    assign ev_o[c] = bus_err_i[c] | (desc_bad && (desc_chan_i == CH_IDX_W'(c)));
  end
endmodule

// File: rtl/dma_setclr_mask.sv
`timescale 1ns/1ps
module dma_setclr_mask #(
  parameter int unsigned W = 14
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] set_i,
  input  logic [W-1:0] clr_i,
  input  logic [W-1:0] force_clr_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] q;

  // clear sources win over set
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q <= '0;
    else         q <= (q | set_i) & ~clr_i & ~force_clr_i;
  end
  assign q_o = q;

  // R2
  set_takes_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|(set_i & ~clr_i & ~force_clr_i)) |=>
      ((q & $past(set_i & ~clr_i & ~force_clr_i)) == $past(set_i & ~clr_i & ~force_clr_i)));

  // R3
  clr_takes_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|clr_i) |=> ((q & $past(clr_i)) == '0));

  // R8
  fault_clr_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|force_clr_i) |=> ((q & $past(force_clr_i)) == '0));

  // R11
  idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (set_i == '0 && clr_i == '0 && force_clr_i == '0) |=> $stable(q));
endmodule

// File: rtl/dma_err_w1c.sv
`timescale 1ns/1ps
module dma_err_w1c #(
  parameter int unsigned W = 14
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] ev_i,
  input  logic [W-1:0] w1c_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] q;

  // event wins over a same-cycle clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q <= '0;
    else         q <= (q & ~w1c_i) | ev_i;
  end
  assign q_o = q;

  // R10
  event_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|ev_i) |=> ((q & $past(ev_i)) == $past(ev_i)));

  // R9
  w1c_clears_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|(w1c_i & ~ev_i)) |=> ((q & $past(w1c_i & ~ev_i)) == '0));

  // R9
  err_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ev_i == '0 && w1c_i == '0) |=> $stable(q));
endmodule

// File: rtl/dma_chan_ctl_regs.sv
`timescale 1ns/1ps
module dma_chan_ctl_regs
  import dma_ctl_pkg::*;
#(
  parameter int unsigned NUM_CH   = NUM_CH_DEF,
  parameter int unsigned DATA_W   = DATA_W_DEF,
  parameter int unsigned ADDR_W   = ADDR_W_DEF,
  parameter int unsigned CH_IDX_W = $clog2(NUM_CH)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [ADDR_W-1:0]   addr_i,
  input  logic                wr_en_i,
  input  logic [DATA_W-1:0]   wr_data_i,
  output logic [DATA_W-1:0]   rd_data_o,
  input  logic [NUM_CH-1:0]   bus_err_i,
  input  logic                desc_fetch_i,
  input  logic [CH_IDX_W-1:0] desc_chan_i,
  input  logic [CC_W-1:0]     desc_cycctl_i,
  output logic [NUM_CH-1:0]   prio_mask_o,
  output logic [NUM_CH-1:0]   en_mask_o
);
  reg_sel_e          sel;
  logic [NUM_CH-1:0] wdata_ch;
  logic [NUM_CH-1:0] err_ev;
  logic [NUM_CH-1:0] pri_set, pri_clr, en_set, en_clr, err_w1c;
  logic [NUM_CH-1:0] pri_q, en_q, err_q;
  logic              unused_wdata_hi;

  assign wdata_ch        = wr_data_i[NUM_CH-1:0];
  assign unused_wdata_hi = ^wr_data_i[DATA_W-1:NUM_CH];

  dma_reg_decode #(.ADDR_W(ADDR_W)) u_decode (
    .addr_i (addr_i),
    .sel_o  (sel)
  );

  assign pri_set = (wr_en_i && sel == SEL_PRI_SET) ? wdata_ch : '0;
  assign pri_clr = (wr_en_i && sel == SEL_PRI_CLR) ? wdata_ch : '0;
  assign en_set  = (wr_en_i && sel == SEL_EN_SET)  ? wdata_ch : '0;
  assign en_clr  = (wr_en_i && sel == SEL_EN_CLR)  ? wdata_ch : '0;
  assign err_w1c = (wr_en_i && sel == SEL_ERR)     ? wdata_ch : '0;

  dma_err_event #(.NUM_CH(NUM_CH), .CH_IDX_W(CH_IDX_W)) u_event (
    .bus_err_i     (bus_err_i),
    .desc_fetch_i  (desc_fetch_i),
    .desc_chan_i   (desc_chan_i),
    .desc_cycctl_i (desc_cycctl_i),
    .ev_o          (err_ev)
  );

  dma_setclr_mask #(.W(NUM_CH)) u_prio (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .set_i       (pri_set),
    .clr_i       (pri_clr),
    .force_clr_i ('0),
    .q_o         (pri_q)
  );

  dma_setclr_mask #(.W(NUM_CH)) u_enable (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .set_i       (en_set),
    .clr_i       (en_clr),
    .force_clr_i (err_ev),
    .q_o         (en_q)
  );

  dma_err_w1c #(.W(NUM_CH)) u_err (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .ev_i   (err_ev),
    .w1c_i  (err_w1c),
    .q_o    (err_q)
  );

  always_comb begin
    rd_data_o = '0;
    case (sel)
      SEL_EN_SET:  rd_data_o[NUM_CH-1:0] = en_q;
      SEL_PRI_SET: rd_data_o[NUM_CH-1:0] = pri_q;
      SEL_ERR:     rd_data_o[NUM_CH-1:0] = err_q;
      default:     rd_data_o = '0;
    endcase
  end

  assign prio_mask_o = pri_q;
  assign en_mask_o   = en_q;

  // R6
  bus_err_latch_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|bus_err_i) |=> ((err_q & $past(bus_err_i)) == $past(bus_err_i)));

  // R7
  valid_desc_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (desc_fetch_i && desc_cycctl_i != '0) |-> (err_ev == bus_err_i));

  // R8
  fault_keeps_prio_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pri_set == '0 && pri_clr == '0 && (|err_ev)) |=> $stable(pri_q));

  // R5
  upper_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_data_o[DATA_W-1:NUM_CH] == '0);
endmodule

// File: tb/test_dma_chan_ctl_regs.sv
`timescale 1ns/1ps
module test_dma_chan_ctl_regs;
  localparam int NCH = 14;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [7:0]  addr_i = '0;
  logic        wr_en_i = 1'b0;
  logic [31:0] wr_data_i = '0;
  logic [31:0] rd_data_o;
  logic [13:0] bus_err_i = '0;
  logic        desc_fetch_i = 1'b0;
  logic [3:0]  desc_chan_i = '0;
  logic [2:0]  desc_cycctl_i = '0;
  logic [13:0] prio_mask_o, en_mask_o;

  always #4 clk_i = ~clk_i;

  dma_chan_ctl_regs i_dma_chan_ctl_regs (
    .clk_i, .rst_ni, .addr_i, .wr_en_i, .wr_data_i, .rd_data_o,
    .bus_err_i, .desc_fetch_i, .desc_chan_i, .desc_cycctl_i,
    .prio_mask_o, .en_mask_o
  );

  typedef struct {
    logic [31:0] rd;
    logic [13:0] pri;
    logic [13:0] en;
    string       tag;
  } exp_t;

  exp_t exp_q[$];
  logic [13:0] m_pri = '0, m_en = '0, m_err = '0;
  int n_run = 0, n_fail = 0;

  function automatic logic [31:0] model_rd(input logic [7:0] a);
    case (a)
      8'h28:   return {18'b0, m_en};
      8'h38:   return {18'b0, m_pri};
      8'h4C:   return {18'b0, m_err};
      default: return '0;
    endcase
  endfunction

  // driver: one bus cycle; optional scoreboard push of the pre-edge state
  task automatic step(input logic [7:0] a, input logic we, input logic [31:0] d,
                      input logic [13:0] be, input logic df, input logic [3:0] dc,
                      input logic [2:0] dcc, input bit chk, input string tag);
    logic [13:0] ev;
    exp_t e;
    @(posedge clk_i); #1;
    addr_i = a; wr_en_i = we; wr_data_i = d;
    bus_err_i = be; desc_fetch_i = df; desc_chan_i = dc; desc_cycctl_i = dcc;
    if (chk) begin
      e.rd = model_rd(a); e.pri = m_pri; e.en = m_en; e.tag = tag;
      exp_q.push_back(e);
    end
    ev = be;
    if (df && dcc == 3'b000 && dc < NCH) ev[dc] = 1'b1;
    if (we && a == 8'h38) m_pri = m_pri | d[13:0];
    if (we && a == 8'h3C) m_pri = m_pri & ~d[13:0];
    if (we && a == 8'h28) m_en  = m_en | d[13:0];
    if (we && a == 8'h2C) m_en  = m_en & ~d[13:0];
    m_en = m_en & ~ev;
    if (we && a == 8'h4C) m_err = m_err & ~d[13:0];
    m_err = m_err | ev;
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    step(a, 1'b1, d, '0, 1'b0, '0, '0, 1'b0, "");
  endtask

  task automatic rd(input logic [7:0] a, input string tag);
    step(a, 1'b0, '0, '0, 1'b0, '0, '0, 1'b1, tag);
  endtask

  task automatic cmp(input string tag, input string what, input logic [31:0] act,
                     input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // monitor: pops at the falling edge of the cycle the item was driven in
  initial begin
    forever begin
      @(negedge clk_i);
      if (exp_q.size() > 0) begin
        exp_t e;
        e = exp_q.pop_front();
        cmp(e.tag, "rd_data", rd_data_o, e.rd);
        cmp(e.tag, "prio_mask", {18'b0, prio_mask_o}, {18'b0, e.pri});
        cmp(e.tag, "en_mask", {18'b0, en_mask_o}, {18'b0, e.en});
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    n_fail++;
    $display("FAIL watchdog all-R actual=hung expected=done");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk_i);
    #1 rst_ni = 1'b1;
    // R1 reset state
    rd(8'h28, "R1"); rd(8'h38, "R1"); rd(8'h4C, "R1");
    // R2 set alias, zero bits no effect
    wr(8'h38, 32'h0005); rd(8'h38, "R2");
    wr(8'h38, 32'h0002); rd(8'h38, "R2");
    wr(8'h38, 32'h0000); rd(8'h38, "R2");
    // R3 clear alias, write-only
    wr(8'h3C, 32'h0001); rd(8'h38, "R3");
    rd(8'h3C, "R3");
    wr(8'h3C, 32'h0000); rd(8'h38, "R3");
    // R4 enable aliases
    wr(8'h28, 32'h3FFF); rd(8'h28, "R4");
    wr(8'h2C, 32'h0100); rd(8'h28, "R4");
    rd(8'h2C, "R4");
    wr(8'h2C, 32'h0000); rd(8'h28, "R4");
    // R5 upper bits
    wr(8'h38, 32'hFFFF_C000); rd(8'h38, "R5");
    wr(8'h38, 32'hFFFF_FFFF); rd(8'h38, "R5");
    wr(8'h3C, 32'hFFFF_C000); rd(8'h38, "R5");
    wr(8'h3C, 32'hFFFF_FFFF); rd(8'h38, "R5");
    wr(8'h38, 32'h0000_2A0F); rd(8'h38, "R5");
    // R11 unmapped offsets
    wr(8'h30, 32'hFFFF_FFFF); wr(8'h00, 32'hFFFF_FFFF); wr(8'h4D, 32'hFFFF_FFFF);
    rd(8'h30, "R11"); rd(8'h28, "R11"); rd(8'h4C, "R11");
    // R6 bus error; R8 only that channel's enable drops, priority kept
    step(8'h00, 1'b0, '0, 14'h0008, 1'b0, '0, '0, 1'b0, "");
    rd(8'h4C, "R6"); rd(8'h28, "R8"); rd(8'h38, "R8");
    step(8'h00, 1'b0, '0, 14'h2001, 1'b0, '0, '0, 1'b0, "");
    rd(8'h4C, "R6"); rd(8'h28, "R8");
    // R7 invalid descriptor, valid descriptor, out-of-range index
    step(8'h00, 1'b0, '0, '0, 1'b1, 4'd5, 3'b000, 1'b0, "");
    rd(8'h4C, "R7"); rd(8'h28, "R7");
    step(8'h00, 1'b0, '0, '0, 1'b1, 4'd6, 3'b011, 1'b0, "");
    rd(8'h4C, "R7");
    step(8'h00, 1'b0, '0, '0, 1'b1, 4'd15, 3'b000, 1'b0, "");
    rd(8'h4C, "R7"); rd(8'h28, "R7");
    step(8'h00, 1'b0, '0, '0, 1'b1, 4'd14, 3'b000, 1'b0, "");
    rd(8'h4C, "R7"); rd(8'h28, "R7");
    // R8 fault wins over same-cycle enable set
    step(8'h28, 1'b1, 32'h0080, 14'h0080, 1'b0, '0, '0, 1'b0, "");
    rd(8'h28, "R8"); rd(8'h4C, "R8");
    step(8'h28, 1'b1, 32'h0400, '0, 1'b1, 4'd10, 3'b000, 1'b0, "");
    rd(8'h28, "R8");
    // R9 write-one-to-clear
    wr(8'h4C, 32'h0000_0008); rd(8'h4C, "R9");
    wr(8'h4C, 32'h0000_0000); rd(8'h4C, "R9");
    // R10 event beats clear
    step(8'h4C, 1'b1, 32'h0020, '0, 1'b1, 4'd5, 3'b000, 1'b0, "");
    rd(8'h4C, "R10");
    step(8'h4C, 1'b1, 32'h0201, 14'h0200, 1'b0, '0, '0, 1'b0, "");
    rd(8'h4C, "R10");
    wr(8'h4C, 32'hFFFF_FFFF); rd(8'h4C, "R9");
    rd(8'h28, "R4"); rd(8'h38, "R2");
    step(8'h00, 1'b0, '0, '0, 1'b0, '0, '0, 1'b0, "");
    wait (exp_q.size() == 0);
    @(posedge clk_i);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule